// File: doc/BRIEF.md
# Indexed Register Access Port

This block gives a CPU a narrow window into a host controller's register set. The bus sees two 16-bit locations, an index port and a data port. Software first writes the index port with a register number. It then reads or writes the data port one or more times. Bit 7 of the index selects the direction of the following data cycles. The lower seven bits choose the register.

Registers numbered below 0x20 are 32 bits wide and move as two data-port beats, with the low half first. Registers numbered 0x20 and above are 16 bits wide and take one beat. On a wide write, the low half waits in a staging register and the register is updated in one step on the high beat. On a wide read, the whole value is captured on the low beat, so the high half that follows comes from the same moment. A hardware status word is mapped as a read-only wide register.

The register file contains:
- a set of read/write 32-bit control words;
- a 16-bit configuration word;
- a fixed identification word;
- a scratch word;
- a reset command that clears the writable state when it is given its key.

Top module: `hcreg_port`

## Requirements
- R1: A write to the index port (bus_asel=1) keeps wdata[6:0] as the register number and wdata[7] as the write flag; 1 = data cycles write, 0 = data cycles read; bits 15:8 are ignored.
- R2: After reset bus_rdata is 0, and every writable register (control words at 0x01..0x03, configuration 0x20, scratch 0x28) reads 0.
- R3: Index 0x27 reads 0x6100 plus the REV parameter (default 0x6122); its upper byte is always 0x61 and writes do not change it.
- R4: Index 0x28 is a 16-bit scratch word and reads back what was last written; index 0x20 behaves the same.
- R5: A read of a register below 0x20 returns the low half on the first data beat and the high half on the second. Both halves come from the value present at the first beat, even when the status word (index 0x10, from stat_in) changes between the two beats.
- R6: A 32-bit write leaves the register unchanged after the low beat and sets all 32 bits on the high beat.
- R7: Every write to the index port returns the beat pointer to the low half, so an abandoned wide access does not shift the next one.
- R8: Writing 0x00F6 to index 0x29 clears the control words, configuration and scratch. Any other value written there changes nothing. Index 0x29 reads 0.
- R9: Unmapped indices (for example 0x05, 0x7E) read 0 and ignore writes. Wide unmapped indices still take two beats.
- R10: A data write while the write flag is 0 is ignored. A data read while the write flag is 1 returns 0 and changes no state.
- R11: bus_rdata changes only on a data-port read cycle; otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Access strobe, high for one cycle per access |
| bus_asel | input | 1 | 1 = index port, 0 = data port |
| bus_wr | input | 1 | Write access |
| bus_rd | input | 1 | Read access |
| bus_wdata | input | 16 | Write data |
| stat_in | input | 32 | Hardware status word, read at index 0x10 |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |

## Verification
The assertions assume the following about the bus:
- each access is a single-cycle bus_cs strobe;
- a strobe never raises bus_wr and bus_rd together;
- read data is consumed only after the clock edge that follows the strobe.

The stimulus drives every access from the falling edge as one strobe cycle followed by an idle cycle, and it never sets both direction lines. This respects the spacing the port may assume between accesses. Random sequences of index writes, wide and narrow data beats and status changes are mixed with directed cases: an abandoned low beat, a snapshot taken across a status change, the reset key and a near-miss value, and accesses in the wrong direction.

// File: rtl/hcreg_pkg.sv
package hcreg_pkg;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 7;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] half_t;

    // indices below this are two-beat (32-bit) registers
    localparam idx_t WIDE_LIMIT = 7'h20;
    localparam idx_t IDX_CFG    = 7'h20;
    localparam idx_t IDX_CHIPID = 7'h27;
    localparam idx_t IDX_SCR    = 7'h28;
    localparam idx_t IDX_SRST   = 7'h29;

    localparam half_t      SRST_KEY  = 16'h00F6;
    localparam logic [7:0] CHIPID_HI = 8'h61;

    typedef struct packed {
        idx_t  idx;
        logic  wflag;
        logic  beat;
        half_t stage;
        half_t hold;
        half_t rdata;
    } seq_state_t;
endpackage

// File: rtl/hcreg_seq.sv
module hcreg_seq
    import hcreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_cs,
    input  logic        bus_asel,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  half_t       bus_wdata,
    input  logic [31:0] rdv_i,
    output idx_t        idx_o,
    output logic        wflag_o,
    output logic        beat_o,
    output logic        we_o,
    output logic [31:0] wval_o,
    output half_t       rdata_o
);
    seq_state_t st_d, st_q;
    logic wide, dwr, drd, bad_rd;

    always_comb begin
        st_d   = st_q;
        we_o   = 1'b0;
        wval_o = '0;
        wide   = (st_q.idx < WIDE_LIMIT);
        dwr    = bus_cs && !bus_asel && bus_wr && st_q.wflag;
        drd    = bus_cs && !bus_asel && bus_rd && !bus_wr && !st_q.wflag;
        bad_rd = bus_cs && !bus_asel && bus_rd && !bus_wr && st_q.wflag;

        if (bus_cs && bus_asel && bus_wr) begin
            st_d.idx   = bus_wdata[IDX_W-1:0];
            st_d.wflag = bus_wdata[IDX_W];
            st_d.beat  = 1'b0;
        end

        if (dwr) begin
            if (wide && !st_q.beat) begin
                st_d.stage = bus_wdata;
                st_d.beat  = 1'b1;
            end else if (wide) begin
                we_o      = 1'b1;
                wval_o    = {bus_wdata, st_q.stage};
                st_d.beat = 1'b0;
            end else begin
                we_o   = 1'b1;
                wval_o = {16'h0000, bus_wdata};
            end
        end

        if (drd) begin
            if (wide && !st_q.beat) begin
                st_d.rdata = rdv_i[15:0];
                st_d.hold  = rdv_i[31:16];
                st_d.beat  = 1'b1;
            end else if (wide) begin
                st_d.rdata = st_q.hold;
                st_d.beat  = 1'b0;
            end else begin
                st_d.rdata = rdv_i[15:0];
            end
        end

        if (bad_rd) begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_o   = st_q.idx;
    assign wflag_o = st_q.wflag;
    assign beat_o  = st_q.beat;
    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/hcreg_file.sv
module hcreg_file
    import hcreg_pkg::*;
#(
    parameter int         NUM_RW   = 3,
    parameter idx_t       RW_BASE  = 7'h01,
    parameter idx_t       STAT_IDX = 7'h10,
    parameter logic [7:0] REV      = 8'h22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  idx_t        idx_i,
    input  logic        we_i,
    input  logic [31:0] wval_i,
    input  logic [31:0] stat_i,
    output logic [31:0] rdv_o
);
    typedef struct packed {
        logic [NUM_RW-1:0][31:0] rw;
        half_t                   cfg;
        half_t                   scr;
    } file_t;

    file_t f_d, f_q;

    always_comb begin
        f_d   = f_q;
        rdv_o = '0;

        if (we_i) begin
            for (int k = 0; k < NUM_RW; k++) begin
                if (idx_i == RW_BASE + idx_t'(k)) f_d.rw[k] = wval_i;
            end
            case (idx_i)
                IDX_CFG: f_d.cfg = wval_i[15:0];
                IDX_SCR: f_d.scr = wval_i[15:0];
                IDX_SRST: begin
                    if (wval_i[15:0] == SRST_KEY) f_d = '0;
                end
                default: ;
            endcase
        end

        for (int k = 0; k < NUM_RW; k++) begin
            if (idx_i == RW_BASE + idx_t'(k)) rdv_o = f_q.rw[k];
        end
        if (idx_i == STAT_IDX) rdv_o = stat_i;
        case (idx_i)
            IDX_CFG:    rdv_o = {16'h0000, f_q.cfg};
            IDX_CHIPID: rdv_o = {16'h0000, CHIPID_HI, REV};
            IDX_SCR:    rdv_o = {16'h0000, f_q.scr};
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end
endmodule

// File: rtl/hcreg_port.sv
module hcreg_port
    import hcreg_pkg::*;
#(
    parameter int         NUM_RW   = 3,
    parameter idx_t       RW_BASE  = 7'h01,
    parameter idx_t       STAT_IDX = 7'h10,
    parameter logic [7:0] REV      = 8'h22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_cs,
    input  logic        bus_asel,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    input  logic [31:0] stat_in,
    output logic [15:0] bus_rdata
);
    idx_t        idx_w;
    logic        wflag_w;
    logic        beat_w;
    logic        we_w;
    logic [31:0] wval_w;
    logic [31:0] rdv_w;

    hcreg_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_asel  (bus_asel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .rdv_i     (rdv_w),
        .idx_o     (idx_w),
        .wflag_o   (wflag_w),
        .beat_o    (beat_w),
        .we_o      (we_w),
        .wval_o    (wval_w),
        .rdata_o   (bus_rdata)
    );

    hcreg_file #(
        .NUM_RW   (NUM_RW),
        .RW_BASE  (RW_BASE),
        .STAT_IDX (STAT_IDX),
        .REV      (REV)
    ) u_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_i  (idx_w),
        .we_i   (we_w),
        .wval_i (wval_w),
        .stat_i (stat_in),
        .rdv_o  (rdv_w)
    );
endmodule

// File: rtl/hcreg_chk.sv
module hcreg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_cs,
    input logic        bus_asel,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic [6:0]  idx,
    input logic        wflag,
    input logic        beat
);
    assert_beat_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_asel && bus_wr) |=> !beat);

    assert_index_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_asel && bus_wr) |=> (idx == $past(bus_wdata[6:0]) && wflag == $past(bus_wdata[7])));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && !bus_asel && bus_rd && !bus_wr) |=> $stable(bus_rdata));

    assert_chipid_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_asel && bus_rd && !bus_wr && !wflag && idx == 7'h27) |=> bus_rdata[15:8] == 8'h61);

    assert_wrong_dir_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_asel && bus_rd && !bus_wr && wflag) |=> (bus_rdata == 16'h0000 && $stable(beat)));

    assert_low_beat_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_asel && bus_wr && wflag && idx < 7'h20 && !beat) |=> beat);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_asel && bus_rd && !bus_wr && !wflag && idx == 7'h7E) |=> bus_rdata == 16'h0000);
endmodule

bind hcreg_port hcreg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_asel  (bus_asel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .idx       (idx_w),
    .wflag     (wflag_w),
    .beat      (beat_w)
);

// File: tb/hcreg_port_tb_top.sv
module hcreg_port_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_asel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] stat_in = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_rw [3];
    logic [15:0] m_cfg, m_scr;

    always #(CLK_P/2) clk = ~clk;

    hcreg_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_asel(bus_asel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .stat_in(stat_in), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic asel, input logic wr, input logic rd, input logic [15:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_asel = asel; bus_wr = wr; bus_rd = rd; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_idx(input logic [7:0] v); acc(1'b1, 1'b1, 1'b0, {8'h00, v}); endtask
    task automatic dwr(input logic [15:0] v);    acc(1'b0, 1'b1, 1'b0, v); endtask
    task automatic drd(output logic [15:0] v);
        acc(1'b0, 1'b0, 1'b1, 16'h0);
        v = bus_rdata;
    endtask

    function automatic bit is_wide(input logic [6:0] i); return i < 7'h20; endfunction

    function automatic logic [31:0] exp_val(input logic [6:0] i);
        case (i)
            7'h01: return m_rw[0];
            7'h02: return m_rw[1];
            7'h03: return m_rw[2];
            7'h10: return stat_in;
            7'h20: return {16'h0, m_cfg};
            7'h27: return 32'h0000_6122;
            7'h28: return {16'h0, m_scr};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_wr(input logic [6:0] i, input logic [31:0] v);
        case (i)
            7'h01: m_rw[0] = v;
            7'h02: m_rw[1] = v;
            7'h03: m_rw[2] = v;
            7'h20: m_cfg = v[15:0];
            7'h28: m_scr = v[15:0];
            7'h29: if (v[15:0] == 16'h00F6) begin
                m_rw[0] = 0; m_rw[1] = 0; m_rw[2] = 0; m_cfg = 0; m_scr = 0;
            end
            default: ;
        endcase
    endtask

    task automatic reg_write(input logic [6:0] i, input logic [31:0] v);
        set_idx({1'b1, i});
        dwr(v[15:0]);
        if (is_wide(i)) dwr(v[31:16]);
        model_wr(i, v);
    endtask

    task automatic reg_check(input string req, input logic [6:0] i);
        logic [15:0] r;
        logic [31:0] e;
        set_idx({1'b0, i});
        e = exp_val(i);
        drd(r);
        chk(req, r, e[15:0]);
        if (is_wide(i)) begin
            drd(r);
            chk(req, r, e[31:16]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [6:0] pick [10] = '{7'h01, 7'h02, 7'h03, 7'h10, 7'h20, 7'h27, 7'h28, 7'h29, 7'h05, 7'h7E};
        void'($urandom(32'd4242));
        m_rw[0] = 0; m_rw[1] = 0; m_rw[2] = 0; m_cfg = 0; m_scr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        chk("R2 rdata after reset", bus_rdata, 16'h0);
        reg_check("R2 ctrl0", 7'h01);
        reg_check("R2 ctrl2", 7'h03);
        reg_check("R2 scratch", 7'h28);
        reg_check("R2 cfg", 7'h20);

        // R3: identification, writes have no effect
        reg_check("R3 chip id", 7'h27);
        reg_write(7'h27, 32'h0000_1234);
        reg_check("R3 chip id after write", 7'h27);

        // R4: scratch and config
        reg_write(7'h28, 32'h0000_A55A);
        reg_check("R4 scratch", 7'h28);
        reg_write(7'h20, 32'h0000_0F0F);
        reg_check("R4 cfg", 7'h20);

        // R1: upper bits of index word ignored
        acc(1'b1, 1'b1, 1'b0, 16'hFFA8);
        dwr(16'h3C3C); m_scr = 16'h3C3C;
        reg_check("R1 index upper bits ignored", 7'h28);

        // R6: low beat alone does not update
        reg_write(7'h02, 32'h1111_2222);
        set_idx(8'h82);
        dwr(16'hBEEF);
        reg_check("R6 after low beat only", 7'h02);
        // R7: pointer realigns after interrupted access
        set_idx(8'h82);
        dwr(16'h4444);
        dwr(16'h5555); m_rw[1] = 32'h5555_4444;
        reg_check("R7 realigned write", 7'h02);
        set_idx(8'h02);
        drd(r);
        set_idx(8'h02);
        drd(r);
        chk("R7 realigned read low", r, 16'h4444);

        // R5: snapshot across status change
        stat_in = 32'hAAAA_1357;
        set_idx(8'h10);
        drd(r);
        chk("R5 status low", r, 16'h1357);
        stat_in = 32'h9999_0000;
        drd(r);
        chk("R5 status high from snapshot", r, 16'hAAAA);

        // R11: output holds across idle cycles and index writes
        repeat (5) @(negedge clk);
        chk("R11 rdata hold", bus_rdata, 16'hAAAA);
        set_idx(8'h81);
        chk("R11 rdata hold after index write", bus_rdata, 16'hAAAA);

        // R8: near-miss then key
        reg_write(7'h01, 32'hDEAD_BEEF);
        reg_write(7'h29, 32'h0000_00F7);
        reg_check("R8 near-miss keeps ctrl", 7'h01);
        reg_check("R8 near-miss keeps scratch", 7'h28);
        reg_check("R8 reset reg reads zero", 7'h29);
        reg_write(7'h29, 32'h0000_00F6);
        reg_check("R8 key clears ctrl0", 7'h01);
        reg_check("R8 key clears ctrl1", 7'h02);
        reg_check("R8 key clears scratch", 7'h28);
        reg_check("R8 key clears cfg", 7'h20);

        // R9: unmapped
        reg_write(7'h7E, 32'h0000_7777);
        reg_check("R9 unmapped narrow", 7'h7E);
        reg_write(7'h05, 32'h1234_5678);
        reg_check("R9 unmapped wide", 7'h05);
        reg_write(7'h28, 32'h0000_0101);
        reg_check("R9 scratch intact", 7'h28);

        // R10: wrong-direction accesses
        set_idx(8'h28);
        dwr(16'hFFFF);
        reg_check("R10 write in read mode ignored", 7'h28);
        set_idx(8'hA8);
        drd(r);
        chk("R10 read in write mode gives zero", r, 16'h0);
        dwr(16'h0202); m_scr = 16'h0202;
        reg_check("R10 scratch after mode mix", 7'h28);

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [6:0] i;
            logic [31:0] v;
            i = pick[$urandom_range(0, 9)];
            v = $urandom;
            if (i == 7'h29 && ($urandom_range(0, 3) == 0)) v[15:0] = 16'h00F6;
            if ($urandom_range(0, 4) == 0) stat_in = $urandom;
            if ($urandom_range(0, 1) == 0) reg_write(i, v);
            else if (is_wide(i)) reg_check("R5 random wide read", i);
            else reg_check("R4 random narrow read", i);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule